// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt requests from six numbered slots and turns them into one request line and a fixed program entry address for a small processor core. The slots are two external pins, overflows from two timers, a periodic time-base tick, and one slot that is kept unused. A one-cycle pulse on a slot's request input sets a sticky latch for that slot. Only hardware can set a latch. Software can clear latches through a clear write, and reset clears all of them.

A latch is eligible when the global enable is on and the mask bit for its slot is set. The first external pin has no mask bit and needs only the global enable. Among the eligible latches, the one with the highest priority drives the request output and the entry address, with no register in that path. When the core acknowledges, the latch being served is cleared and the global enable drops. Software must set the enable again before another interrupt can be taken.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), all latches, the global enable and all four mask bits are 0, irq is low and vec is 0.
- R2: A high bit on src_req sets the latch for that slot at the next edge, whatever the enable and mask state. Slot bits are: 5 first external pin, 4 reserved, 3 timer A overflow, 2 timer B overflow, 1 time-base tick, 0 second external pin. The reserved bit 4 never sets a latch. No software write can set a latch.
- R3: irq is high only when the global enable is 1 and at least one latch is eligible. When irq is low, vec is 0. Both outputs follow the registered state in the same cycle.
- R4: When several latches are eligible, the one with the highest slot number is selected (slot 5 first, slot 0 last). A newly eligible latch of higher priority takes over the output in the cycle after its request.
- R5: vec carries the entry address of the selected slot: slot 5 gives 0x002, slot 3 gives 0x006, slot 2 gives 0x008, slot 1 gives 0x00A and slot 0 gives 0x00C. Address 0x004 belongs to the reserved slot 4 and is never output.
- R6: Slot 5 needs only the global enable. Slots 3, 2, 1 and 0 also need mask bits 3, 2, 1 and 0 of the mask register, which is loaded from mask_wdata when mask_we is high.
- R7: An ack while irq is high clears the selected latch and the global enable at the next edge. An ack while irq is low changes nothing.
- R8: clr_we high clears every latch whose bit is set in clr_mask (same slot numbering as R2). A request on the same slot in the same cycle wins, and the latch stays set.
- R9: The global enable is set by ei_set and cleared by ei_clr. A served ack overrides both, and ei_clr overrides ei_set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 6 | Request pulses, one bit per slot |
| ei_set | input | 1 | Software write: set global enable |
| ei_clr | input | 1 | Software write: clear global enable |
| mask_we | input | 1 | Software write strobe for the mask register |
| mask_wdata | input | 4 | New mask value |
| clr_we | input | 1 | Software write strobe for latch clear |
| clr_mask | input | 6 | Latches to clear, one bit per slot |
| ack | input | 1 | Core acknowledges the presented interrupt |
| irq | output | 1 | Interrupt request to the core |
| vec | output | ADDR_W | Program entry address of the selected slot |

## Verification
All six slots are latched at once while the enable is off and then drained one ack at a time. This exposes the order of service and shows that the reserved address is skipped. Mixed patterns use only the unmasked pin with a masked timer, then toggle single mask bits, which separates the mask gating from the latching. Same-cycle collisions are also driven: clear against request, ack against enable set, and set against clear. These pin down each override. A late higher-priority arrival checks that selection is recomputed every cycle. A behavioural model is compared on every clock throughout.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int N_SLOT    = 6;
    localparam int MASK_W    = N_SLOT - 2;
    localparam int IDX_W     = $clog2(N_SLOT);

    localparam int SLOT_EXT0 = 5;
    localparam int SLOT_RSV  = 4;
    localparam int SLOT_TMRA = 3;
    localparam int SLOT_TMRB = 2;
    localparam int SLOT_TICK = 1;
    localparam int SLOT_EXT1 = 0;

    typedef logic [N_SLOT-1:0] slot_vec_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Per-slot gate: enable combined with the slot's mask bit.
    function automatic slot_vec_t gate_map(input logic ei, input logic [MASK_W-1:0] m);
        slot_vec_t g;
        g            = '0;
        g[SLOT_EXT0] = ei;
        g[SLOT_RSV]  = 1'b0;
        g[SLOT_TMRA] = ei & m[3];
        g[SLOT_TMRB] = ei & m[2];
        g[SLOT_TICK] = ei & m[1];
        g[SLOT_EXT1] = ei & m[0];
        return g;
    endfunction

    // Entry address rises by two per priority step below the top slot.
    function automatic int unsigned entry_of(input logic [IDX_W-1:0] idx);
        return 2 * (N_SLOT - int'(idx));
    endfunction

endpackage

// File: rtl/irqc_latch_bank.sv
module irqc_latch_bank
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_vec_t req,
    input  slot_vec_t sw_clr,
    input  slot_vec_t ack_clr,
    output slot_vec_t lat
);

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        localparam logic SET_OK = (g != SLOT_RSV);

        always_ff @(posedge clk) begin
            if (rst)
                lat[g] <= 1'b0;
            else
                lat[g] <= (lat[g] & ~sw_clr[g] & ~ack_clr[g]) | (req[g] & SET_OK);
        end

        // A latch only rises after a hardware request on its slot.
        p_hw_set_only_r2: assert property (@(posedge clk) disable iff (rst)
            (lat[g] && !$past(lat[g])) |-> $past(req[g]));
    end

endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ei_set,
    input  logic              ei_clr,
    input  logic              ack_hit,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    output logic              ei,
    output logic [MASK_W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst)
            ei <= 1'b0;
        else if (ack_hit)
            ei <= 1'b0;
        else if (ei_clr)
            ei <= 1'b0;
        else if (ei_set)
            ei <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (mask_we)
            mask <= mask_wdata;
    end

    p_ack_drops_ei_r7: assert property (@(posedge clk) disable iff (rst)
        ack_hit |=> !ei);

    p_clr_beats_set_r9: assert property (@(posedge clk) disable iff (rst)
        (ei_clr && !ack_hit) |=> !ei);

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick
    import irqc_pkg::*;
(
    input  slot_vec_t elig,
    output pick_t     pick,
    output slot_vec_t sel
);

    always_comb begin
        pick = '0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (elig[i]) begin
                pick.hit = 1'b1;
                pick.idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        sel = '0;
        if (pick.hit)
            sel[pick.idx] = 1'b1;
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        src_req,
    input  logic              ei_set,
    input  logic              ei_clr,
    input  logic              mask_we,
    input  logic [3:0]        mask_wdata,
    input  logic              clr_we,
    input  logic [5:0]        clr_mask,
    input  logic              ack,
    output logic              irq,
    output logic [ADDR_W-1:0] vec
);

    slot_vec_t         lat;
    slot_vec_t         elig;
    slot_vec_t         sel;
    slot_vec_t         sw_clr;
    slot_vec_t         ack_clr;
    pick_t             pick;
    logic              ei;
    logic [MASK_W-1:0] mask;
    logic              ack_hit;

    assign ack_hit = ack & pick.hit;
    assign ack_clr = ack_hit ? sel : '0;
    assign sw_clr  = clr_we ? clr_mask : '0;

    irqc_latch_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (src_req),
        .sw_clr  (sw_clr),
        .ack_clr (ack_clr),
        .lat     (lat)
    );

    irqc_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .ei_set     (ei_set),
        .ei_clr     (ei_clr),
        .ack_hit    (ack_hit),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .ei         (ei),
        .mask       (mask)
    );

    assign elig = lat & gate_map(ei, mask);

    irqc_prio_pick u_pick (
        .elig (elig),
        .pick (pick),
        .sel  (sel)
    );

    assign irq = pick.hit;
    assign vec = pick.hit ? ADDR_W'(entry_of(pick.idx)) : '0;

    p_irq_needs_ei_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> ei);

    p_idle_vec_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (vec == '0));

    p_ack_clears_served_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> ((lat & $past(sel) & ~$past(src_req)) == '0));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  src_req = '0;
    logic        ei_set = 1'b0, ei_clr = 1'b0, mask_we = 1'b0, clr_we = 1'b0, ack = 1'b0;
    logic [3:0]  mask_wdata = '0;
    logic [5:0]  clr_mask = '0;
    logic        irq;
    logic [11:0] vec;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    irq_vector_ctrl #(.ADDR_W(12)) u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .ei_set(ei_set), .ei_clr(ei_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we), .clr_mask(clr_mask),
        .ack(ack), .irq(irq), .vec(vec)
    );

    // Behavioural reference state
    bit [5:0] m_lat  = '0;
    bit       m_ei   = 1'b0;
    bit [3:0] m_mask = '0;

    function automatic bit allowed(int i);
        case (i)
            5:       return m_ei;
            3:       return m_ei && m_mask[3];
            2:       return m_ei && m_mask[2];
            1:       return m_ei && m_mask[1];
            0:       return m_ei && m_mask[0];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int m_pick();
        for (int i = 5; i >= 0; i--)
            if (m_lat[i] && allowed(i)) return i;
        return -1;
    endfunction

    function automatic logic [11:0] addr_for(int i);
        case (i)
            5:       return 12'h002;
            3:       return 12'h006;
            2:       return 12'h008;
            1:       return 12'h00A;
            0:       return 12'h00C;
            default: return 12'h000;
        endcase
    endfunction

    always @(posedge clk) begin
        int       p;
        bit [5:0] nl;
        if (rst) begin
            m_lat = '0; m_ei = 1'b0; m_mask = '0;
        end else begin
            p  = m_pick();
            nl = m_lat;
            if (clr_we) nl &= ~clr_mask;
            if (ack && p >= 0) nl[p] = 1'b0;
            nl |= src_req & 6'b101111;
            m_lat = nl;
            if (ack && p >= 0)  m_ei = 1'b0;
            else if (ei_clr)    m_ei = 1'b0;
            else if (ei_set)    m_ei = 1'b1;
            if (mask_we) m_mask = mask_wdata;
        end
    end

    task automatic check(string tag, logic exp_irq, logic [11:0] exp_vec);
        checks++;
        if (irq !== exp_irq || vec !== exp_vec) begin
            errors++;
            $display("FAIL %s irq=%0b vec=%03h expected irq=%0b vec=%03h",
                     tag, irq, vec, exp_irq, exp_vec);
        end
    endtask

    // One cycle: inputs already set; compare after the edge, then drop pulses.
    task automatic tick();
        int p;
        @(negedge clk);
        p = m_pick();
        check(cur_tag, p >= 0, addr_for(p));
        src_req = '0; ei_set = 0; ei_clr = 0; mask_we = 0; clr_we = 0; ack = 0;
        clr_mask = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur_tag = "R1";
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1", 1'b0, 12'h000);

        // R2: latch everything while disabled, reserved included
        cur_tag = "R2";
        src_req = 6'b111111; tick();
        check("R3", 1'b0, 12'h000);
        mask_we = 1; mask_wdata = 4'hF; tick();
        check("R3", 1'b0, 12'h000);
        ei_set = 1; tick();
        check("R5", 1'b1, 12'h002);
        cur_tag = "R7";
        ack = 1; tick();
        check("R7", 1'b0, 12'h000);
        cur_tag = "R4";
        ei_set = 1; tick();
        check("R4", 1'b1, 12'h006);
        ack = 1; tick(); ei_set = 1; tick();
        check("R4", 1'b1, 12'h008);
        ack = 1; tick(); ei_set = 1; tick();
        check("R5", 1'b1, 12'h00A);
        ack = 1; tick(); ei_set = 1; tick();
        check("R5", 1'b1, 12'h00C);
        ack = 1; tick(); ei_set = 1; tick();
        check("R2", 1'b0, 12'h000);

        // R6: unmasked pin versus masked timer
        cur_tag = "R6";
        mask_we = 1; mask_wdata = 4'h0; tick();
        src_req = 6'b101000; tick();
        check("R6", 1'b1, 12'h002);
        ack = 1; tick(); ei_set = 1; tick();
        check("R6", 1'b0, 12'h000);
        mask_we = 1; mask_wdata = 4'b1000; tick();
        check("R6", 1'b1, 12'h006);
        mask_we = 1; mask_wdata = 4'b0111; tick();
        check("R6", 1'b0, 12'h000);

        // R8: software clear and collision with a request
        cur_tag = "R8";
        clr_we = 1; clr_mask = 6'b001000; tick();
        mask_we = 1; mask_wdata = 4'hF; tick();
        check("R8", 1'b0, 12'h000);
        src_req = 6'b000010; clr_we = 1; clr_mask = 6'b000010; tick();
        check("R8", 1'b1, 12'h00A);
        clr_we = 1; clr_mask = 6'b000010; tick();
        check("R8", 1'b0, 12'h000);

        // R7: ack with nothing pending leaves the enable alone
        cur_tag = "R7";
        ack = 1; tick();
        src_req = 6'b000001; tick();
        check("R7", 1'b1, 12'h00C);

        // R4: higher priority arrives while lower is shown
        cur_tag = "R4";
        src_req = 6'b000100; tick();
        check("R4", 1'b1, 12'h008);

        // R9: overrides on the enable
        cur_tag = "R9";
        ack = 1; ei_set = 1; tick();
        check("R9", 1'b0, 12'h000);
        ei_set = 1; ei_clr = 1; tick();
        check("R9", 1'b0, 12'h000);
        ei_set = 1; tick();
        check("R9", 1'b1, 12'h00C);
        ei_clr = 1; tick();
        check("R3", 1'b0, 12'h000);

        repeat (2) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule